// File: doc/BRIEF.md
# Power-Up Strap Configuration Sequencer

This block captures the board-level configuration straps once, a fixed time after the chip's active-low power-down input is released, and then holds the decoded operating configuration for the rest of the session. The speed and duplex straps are three-level inputs. Analog sensing converts each of them to a two-bit code before it reaches this block. The block turns the two codes into the set of enabled line rates, the auto-negotiation enable, and the transparent/non-transparent repeat mode. It also assembles a five-bit management address from the address straps and decides whether the link-loss warning feature may run.

While power-down is low, every register is held cleared and the configuration-valid flag is low. After release, the input goes through a two-stage synchronizer. A timer then counts a fixed window, 125,000 cycles by default (5 ms at 25 MHz). On the last cycle of the window the straps are decoded and loaded into the holding register, and the valid flag rises in the same step. If power-down falls again before that point, the sequence stops. The next release starts a full new window.

Top module: `strap_cfg_seq`

## Requirements
- R1: While `pwr_dn_n` is low, `cfg_valid` and every configuration output are 0. This takes effect without waiting for a clock edge.
- R2: After `pwr_dn_n` rises, `cfg_valid` is first seen high after exactly DELAY_CYCLES+2 rising clock edges: two synchronizer stages plus the timer window. It is low after DELAY_CYCLES+1 edges. It stays high until the next power-down.
- R3: Every configuration output takes the strap values present at the edge where `cfg_valid` rises. Later strap changes have no effect until a new power-down/release sequence.
- R4: Speed code 2'b10 (high) gives `rate100_en`=1, `rate10_en`=0, `autoneg_en`=0 and `transparent`=0.
- R5: Speed code 2'b00 (low) gives `rate10_en`=1, `rate100_en`=0, `autoneg_en`=0 and `transparent`=0.
- R6: Speed code 2'b01 (mid) gives `rate100_en`=1, `rate10_en`=1 and `autoneg_en`=1.
- R7: With speed at mid, `transparent`=1 when the duplex code is 2'b01 (mid). It is 0 when the duplex code is 2'b00 or 2'b10.
- R8: `mgmt_addr` = {`addr4_warn`, `addr_hi[1:0]`, `addr_lo[1:0]`}, with bit 4 the MSB.
- R9: `warn_en` = `addr4_warn` AND (speed code is high or low). It is therefore 0 whenever both rates are enabled.
- R10: A falling edge of `pwr_dn_n` during the window stops the sequence. After the next release, a full DELAY_CYCLES+2 edges pass before `cfg_valid` rises.
- R11: Code 2'b11 on either the speed or the duplex input is decoded as mid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| pwr_dn_n | input | 1 | Active-low power-down; asynchronous clear, released to start the sampling window |
| speed_lvl | input | 2 | Speed strap level code: 00 low, 01 mid, 10 high, 11 read as mid |
| duplex_lvl | input | 2 | Duplex strap level code, same encoding |
| addr4_warn | input | 1 | Address bit 4 strap, also the warning-feature request |
| addr_hi | input | 2 | Address bits 3:2 strap |
| addr_lo | input | 2 | Address bits 1:0 strap |
| rate100_en | output | 1 | 100 Mb/s operation enabled |
| rate10_en | output | 1 | 10 Mb/s operation enabled |
| autoneg_en | output | 1 | Auto-negotiation enabled |
| transparent | output | 1 | Transparent repeat mode selected |
| warn_en | output | 1 | Link-loss warning feature enabled |
| mgmt_addr | output | 5 | Management address |
| cfg_valid | output | 1 | Latched configuration is valid |

## Verification
The bound checker tests the following invariants on every cycle:
- `cfg_valid` is low during power-down and never drops while power stays up.
- The held outputs do not move while valid.
- The valid flag rises only on the internal sample strobe.
- The strobe fires after exactly the window length, measured by an independent counter.
- The decoded rate, negotiation, transparent and warning bits are mutually consistent.

Only the bench scenarios can show the rest:
- that each strap combination maps to the right output values, including the 2'b11 codes;
- that the address is assembled from the right straps;
- that strap changes after latching are ignored;
- that an aborted window restarts in full.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_BAD  = 2'b11
  } lvl_e;

  typedef struct packed {
    logic       rate100;
    logic       rate10;
    logic       autoneg;
    logic       transparent;
    logic       warn;
    logic [4:0] addr;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Fold the unused code onto mid level (R11).
  function automatic lvl_e norm_lvl(input logic [1:0] code);
    lvl_e l;
    if (code == 2'b11) l = LVL_MID;
    else               l = lvl_e'(code);
    return l;
  endfunction

  function automatic cfg_t decode_straps(
    input logic [1:0] speed_code,
    input logic [1:0] duplex_code,
    input logic       warn_req,
    input logic [1:0] a_hi,
    input logic [1:0] a_lo
  );
    cfg_t c;
    lvl_e sp;
    lvl_e dx;
    sp = norm_lvl(speed_code);
    dx = norm_lvl(duplex_code);
    c.rate100     = (sp != LVL_LOW);                   // R4 R6
    c.rate10      = (sp != LVL_HIGH);                  // R5 R6
    c.autoneg     = (sp == LVL_MID);                   // R6
    c.transparent = (sp == LVL_MID) && (dx == LVL_MID); // R7
    c.warn        = warn_req && (sp != LVL_MID);       // R9
    c.addr        = {warn_req, a_hi, a_lo};            // R8
    return c;
  endfunction

endpackage

// File: rtl/strap_release_sync.sv
module strap_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic run
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign run = sh_q[STAGES-1];
endmodule

// File: rtl/strap_delay_timer.sv
module strap_delay_timer #(
  parameter int DELAY_CYCLES = 125000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  output logic sample_stb,
  output logic done
);
  localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (run && !done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sample_stb = run && !done_q && (cnt_q == LAST);
  assign done       = done_q;
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_cfg_pkg::*;
(
  input  logic [1:0] speed_lvl,
  input  logic [1:0] duplex_lvl,
  input  logic       addr4_warn,
  input  logic [1:0] addr_hi,
  input  logic [1:0] addr_lo,
  output cfg_t       cfg_next
);
  always_comb cfg_next = decode_straps(speed_lvl, duplex_lvl, addr4_warn, addr_hi, addr_lo);
endmodule

// File: rtl/strap_cfg_hold.sv
module strap_cfg_hold
  import strap_cfg_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic load,
  input  cfg_t cfg_in,
  output cfg_t cfg_q,
  output logic valid_q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      cfg_q   <= cfg_in;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_cfg_seq.sv
module strap_cfg_seq
  import strap_cfg_pkg::*;
#(
  parameter int DELAY_CYCLES = 125000
) (
  input  logic       clk,
  input  logic       pwr_dn_n,
  input  logic [1:0] speed_lvl,
  input  logic [1:0] duplex_lvl,
  input  logic       addr4_warn,
  input  logic [1:0] addr_hi,
  input  logic [1:0] addr_lo,
  output logic       rate100_en,
  output logic       rate10_en,
  output logic       autoneg_en,
  output logic       transparent,
  output logic       warn_en,
  output logic [4:0] mgmt_addr,
  output logic       cfg_valid
);
  // Named internal events, visible to the bound checker.
  logic run;
  logic sample_stb;
  logic window_done;
  cfg_t cfg_next;
  cfg_t cfg_q;

  strap_release_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .arst_n (pwr_dn_n),
    .run    (run)
  );

  strap_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk        (clk),
    .arst_n     (pwr_dn_n),
    .run        (run),
    .sample_stb (sample_stb),
    .done       (window_done)
  );

  strap_decode u_dec (
    .speed_lvl  (speed_lvl),
    .duplex_lvl (duplex_lvl),
    .addr4_warn (addr4_warn),
    .addr_hi    (addr_hi),
    .addr_lo    (addr_lo),
    .cfg_next   (cfg_next)
  );

  strap_cfg_hold u_hold (
    .clk     (clk),
    .arst_n  (pwr_dn_n),
    .load    (sample_stb),
    .cfg_in  (cfg_next),
    .cfg_q   (cfg_q),
    .valid_q (cfg_valid)
  );

  assign rate100_en  = cfg_q.rate100;
  assign rate10_en   = cfg_q.rate10;
  assign autoneg_en  = cfg_q.autoneg;
  assign transparent = cfg_q.transparent;
  assign warn_en     = cfg_q.warn;
  assign mgmt_addr   = cfg_q.addr;
endmodule

// File: rtl/strap_cfg_seq_chk.sv
module strap_cfg_seq_chk #(
  parameter int DELAY_CYCLES = 125000
) (
  input logic       clk,
  input logic       pwr_dn_n,
  input logic       run,
  input logic       sample_stb,
  input logic       rate100_en,
  input logic       rate10_en,
  input logic       autoneg_en,
  input logic       transparent,
  input logic       warn_en,
  input logic [4:0] mgmt_addr,
  input logic       cfg_valid
);
  // Independent count of cycles spent with the synchronized release high.
  logic [31:0] run_cycles;
  always_ff @(posedge clk or negedge pwr_dn_n) begin
    if (!pwr_dn_n)                               run_cycles <= '0;
    else if (run && run_cycles < DELAY_CYCLES)   run_cycles <= run_cycles + 1;
  end

  a_r1_invalid_in_pd: assert property (@(posedge clk) !pwr_dn_n |-> !cfg_valid);

  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    cfg_valid |=> cfg_valid);

  a_r2_window: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    sample_stb |-> (run_cycles == 32'(DELAY_CYCLES - 1)));

  a_r2_rise_on_stb: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    $rose(cfg_valid) |-> $past(sample_stb));

  a_r3_hold: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    cfg_valid |=> ($stable(mgmt_addr) && $stable(rate100_en) && $stable(rate10_en)
                   && $stable(autoneg_en) && $stable(transparent) && $stable(warn_en)));

  a_r6_rate_set: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    cfg_valid |-> ((rate100_en || rate10_en) && (autoneg_en == (rate100_en && rate10_en))));

  a_r7_transparent_needs_mid: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    transparent |-> autoneg_en);

  a_r9_warn_single_rate: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    warn_en |-> ((rate100_en ^ rate10_en) && mgmt_addr[4]));
endmodule

bind strap_cfg_seq strap_cfg_seq_chk #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
  .clk         (clk),
  .pwr_dn_n    (pwr_dn_n),
  .run         (run),
  .sample_stb  (sample_stb),
  .rate100_en  (rate100_en),
  .rate10_en   (rate10_en),
  .autoneg_en  (autoneg_en),
  .transparent (transparent),
  .warn_en     (warn_en),
  .mgmt_addr   (mgmt_addr),
  .cfg_valid   (cfg_valid)
);

// File: tb/strap_cfg_seq_test.sv
`timescale 1ns/100ps
module strap_cfg_seq_test;
  localparam int D = 20;

  logic       clk = 1'b0;
  logic       pwr_dn_n = 1'b0;
  logic [1:0] speed_lvl = 2'b00, duplex_lvl = 2'b00, addr_hi = 2'b00, addr_lo = 2'b00;
  logic       addr4_warn = 1'b0;
  logic       rate100_en, rate10_en, autoneg_en, transparent, warn_en, cfg_valid;
  logic [4:0] mgmt_addr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  strap_cfg_seq #(.DELAY_CYCLES(D)) uut (
    .clk(clk), .pwr_dn_n(pwr_dn_n), .speed_lvl(speed_lvl), .duplex_lvl(duplex_lvl),
    .addr4_warn(addr4_warn), .addr_hi(addr_hi), .addr_lo(addr_lo),
    .rate100_en(rate100_en), .rate10_en(rate10_en), .autoneg_en(autoneg_en),
    .transparent(transparent), .warn_en(warn_en), .mgmt_addr(mgmt_addr), .cfg_valid(cfg_valid)
  );

  // Expected {rate100, rate10, autoneg, transparent, warn, addr[4:0]} from the requirements.
  function automatic logic [9:0] expect_cfg(input logic [1:0] sp, input logic [1:0] dx,
                                            input logic w, input logic [1:0] hi, input logic [1:0] lo);
    int s; int d;
    logic r100, r10, an, tr, wn;
    s = (sp == 2'b00) ? 0 : (sp == 2'b10) ? 2 : 1;  // R11: 11 -> mid
    d = (dx == 2'b00) ? 0 : (dx == 2'b10) ? 2 : 1;
    case (s)
      0: begin r100 = 0; r10 = 1; an = 0; tr = 0; end            // R5
      2: begin r100 = 1; r10 = 0; an = 0; tr = 0; end            // R4
      default: begin r100 = 1; r10 = 1; an = 1; tr = (d == 1); end // R6 R7
    endcase
    wn = w && (s != 1);                                          // R9
    return {r100, r10, an, tr, wn, w, hi, lo};                   // R8
  endfunction

  function automatic logic [10:0] dut_vec();
    return {cfg_valid, rate100_en, rate10_en, autoneg_en, transparent, warn_en, mgmt_addr};
  endfunction

  task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: edge count since release, one-shot capture.
  int edges_up = 0;
  logic [10:0] ref_vec = '0;
  always @(posedge clk) begin
    if (!pwr_dn_n) begin
      edges_up = 0;
      ref_vec = '0;
    end else begin
      if (edges_up < D + 2) edges_up++;
      if (edges_up == D + 2 && !ref_vec[10])
        ref_vec = {1'b1, expect_cfg(speed_lvl, duplex_lvl, addr4_warn, addr_hi, addr_lo)};
    end
  end

  always @(negedge clk) if (!finished) check("R1/R2/R3 per-cycle", dut_vec(), ref_vec);

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_straps(input logic [1:0] sp, input logic [1:0] dx, input logic w,
                            input logic [1:0] hi, input logic [1:0] lo);
    speed_lvl = sp; duplex_lvl = dx; addr4_warn = w; addr_hi = hi; addr_lo = lo;
  endtask

  task automatic run_case(input string tag, input logic [1:0] sp, input logic [1:0] dx,
                          input logic w, input logic [1:0] hi, input logic [1:0] lo);
    logic [10:0] exp;
    exp = {1'b1, expect_cfg(sp, dx, w, hi, lo)};
    @(negedge clk); #1 pwr_dn_n = 1'b0; set_straps(sp, dx, w, hi, lo);
    cycles(3);
    check("R1 outputs cleared in power-down", dut_vec(), 11'h000);
    #1 pwr_dn_n = 1'b1;
    cycles(D + 1);
    check("R2 not yet valid at D+1 edges", {10'h0, cfg_valid}, 11'h000);
    cycles(1);
    check({tag, " decode at D+2 edges"}, dut_vec(), exp);
    #1 set_straps(~sp, ~dx, ~w, ~hi, ~lo);
    cycles(6);
    check("R3 later strap change ignored", dut_vec(), exp);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cycles(2);
    check("R1 reset state", dut_vec(), 11'h000);

    run_case("R4 speed high",            2'b10, 2'b01, 1'b1, 2'b01, 2'b10);
    run_case("R5 speed low",             2'b00, 2'b10, 1'b1, 2'b11, 2'b00);
    run_case("R6 R7 mid/mid transparent",2'b01, 2'b01, 1'b1, 2'b10, 2'b01);
    run_case("R7 mid/low non-transp",    2'b01, 2'b00, 1'b0, 2'b00, 2'b11);
    run_case("R7 mid/high non-transp",   2'b01, 2'b10, 1'b0, 2'b01, 2'b01);
    run_case("R11 speed 11 duplex 11",   2'b11, 2'b11, 1'b1, 2'b00, 2'b00);
    run_case("R9 R8 high no warn req",   2'b10, 2'b11, 1'b0, 2'b11, 2'b11);

    // R10: abort mid-window, then a full window after the next release.
    @(negedge clk); #1 pwr_dn_n = 1'b0; set_straps(2'b00, 2'b01, 1'b1, 2'b01, 2'b01);
    cycles(2);
    #1 pwr_dn_n = 1'b1;
    cycles(D / 2);
    #1 pwr_dn_n = 1'b0;
    cycles(1);
    check("R10 abort clears", dut_vec(), 11'h000);
    cycles(2);
    #1 pwr_dn_n = 1'b1;
    cycles(D + 1);
    check("R10 restarted window not yet valid", {10'h0, cfg_valid}, 11'h000);
    cycles(1);
    check("R10 valid after full window", dut_vec(),
          {1'b1, expect_cfg(2'b00, 2'b01, 1'b1, 2'b01, 2'b01)});

    cycles(3);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule